// File: doc/BRIEF.md
# Hardwired Single-Accumulator Processor

This block is a small 16-bit processor built around one accumulator, a one-bit link register and a 12-bit program counter. A four-bit state counter feeds a one-hot state decoder and the three opcode bits feed a second decoder. Together they step each instruction through fixed states: fetch, decode, an optional indirect address fetch, and a short execute tail. Every register transfer passes over one internal 16-bit bus. A 3-bit code picks the source that drives that bus.

The processor sits next to a 4096-word by 16-bit memory. It drives the address, a read strobe, a write strobe and the write data. Read data must come back within the same clock cycle. A character input port and a character output port each have a ready flag. A pending flag can divert the processor into a three-state hardware call: the return address goes to word 0 and execution resumes at word 1. A halt instruction stops all sequencing until the next reset. Debug outputs show the program counter, the accumulator and the halted state.

Instruction word: bit 15 is the indirect flag, bits 14..12 are the opcode and bits 11..0 are the address. Opcodes 0..6 are AND, ADD, LDA, STA, BUN, BSA and ISZ. Opcode 7 with bit 15 clear is a register operation. Opcode 7 with bit 15 set is an I/O operation. For both of these, bits 11..0 select the action one bit per action.

Top module: `acc_cpu`

## Requirements
- R1: A synchronous active-high reset clears the program counter, accumulator, link and both ready flags, and leaves the processor running. The first instruction is then fetched from address 0. Each fetch reads the word at the program counter and then advances the program counter by one.
- R2: An instruction takes a fixed number of clocks. Register and I/O operations take 4. STA and BUN take 5. AND, ADD, LDA and BSA take 6. ISZ takes 7. The indirect flag adds no clocks. The state counter never goes past its seventh state.
- R3: Read and write strobes are never both high. Writes occur only in execute states 4 to 6 or in the second state of the hardware call.
- R4: AND, ADD and LDA (opcodes 0, 1, 2) combine the accumulator with the memory operand. ADD puts its carry-out into the link.
- R5: STA (3) writes the accumulator to the operand address. BUN (4) jumps to the operand address. BSA (5) writes the return address at the operand address and continues at the operand address plus one.
- R6: ISZ (6) writes back the operand plus one, and skips the next instruction when that result is zero.
- R7: When bit 15 is set, the effective address is bits 11..0 of the memory word at the instruction's address field.
- R8: Register operations use opcode 7 with bit 15 clear (0x7xxx). The bits are: 11 clear accumulator, 10 clear link, 9 complement accumulator, 8 complement link, 7 rotate right through link, 6 rotate left through link, 5 increment accumulator.
- R9: In register operations the test bits skip one instruction when their condition holds. Bit 4 skips if the accumulator is non-negative, bit 3 if it is negative, bit 2 if it is zero, and bit 1 if the link is zero.
- R10: Register operation bit 0 halts the processor. While halted, the program counter and accumulator hold their values and no memory access occurs.
- R11: I/O operations use 0xFxxx. Bit 11 copies the input character into accumulator bits 7..0, keeps bits 15..8 and clears the input flag. Bit 10 copies accumulator bits 7..0 to the output character and clears the output flag. Bits 9 and 8 skip when the input or output flag is set. Bit 7 enables the hardware call and bit 6 disables it.
- R12: If the hardware call is enabled and either flag is set by the end of an instruction, the next three clocks store the program counter at word 0, set the program counter to 1 and disable further calls.
- R13: An input strobe loads the input character and sets the input flag. An output acknowledge sets the output flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Memory read strobe, data expected in the same cycle |
| mem_wr | output | 1 | Memory write strobe, taken at the clock edge |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| in_char | input | 8 | Character offered by the input device |
| in_strobe | input | 1 | Input character valid, sets the input flag |
| out_ack | input | 1 | Output device ready, sets the output flag |
| out_char | output | 8 | Character register for the output device |
| in_flag | output | 1 | Input flag |
| out_flag | output | 1 | Output flag |
| dbg_pc | output | 12 | Program counter |
| dbg_ac | output | 16 | Accumulator |
| dbg_halted | output | 1 | Processor halted |

## Verification
Some rules are checked by assertions on every clock. These are: the read and write strobes never overlap, writes fall only in the allowed states, the state counter stays within its range, register and I/O operations end after four clocks, every fetch reads at the program counter, the hardware call lands at word 1 with calls disabled, and nothing moves after a halt. Other behaviour only the bench programs can show. This covers arithmetic results and the link carry, the effective address of indirect operands, skip outcomes under each test, the exact clock totals of mixed instruction streams, the return address saved by the hardware call, and the character data moved through the I/O registers.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int CHAR_W = 8;
    localparam int OPC_W  = 3;
    localparam int SC_W   = 4;
    localparam int N_OPC  = 1 << OPC_W;
    localparam int N_TS   = 1 << SC_W;
    localparam int LAST_TS = 6;

    localparam int OP_AND = 0;
    localparam int OP_ADD = 1;
    localparam int OP_LDA = 2;
    localparam int OP_STA = 3;
    localparam int OP_BUN = 4;
    localparam int OP_BSA = 5;
    localparam int OP_ISZ = 6;
    localparam int OP_EXT = 7;

    // register-operation bits
    localparam int RB_CLA = 11, RB_CLE = 10, RB_CMA = 9, RB_CME = 8;
    localparam int RB_SHR = 7,  RB_SHL = 6,  RB_INC = 5, RB_SPOS = 4;
    localparam int RB_SNEG = 3, RB_SZAC = 2, RB_SZL = 1, RB_HALT = 0;
    // I/O-operation bits
    localparam int IB_IN = 11, IB_OUT = 10, IB_SKIN = 9, IB_SKOUT = 8;
    localparam int IB_EN = 7,  IB_DIS = 6;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0, SEL_AR = 3'd1, SEL_PC = 3'd2, SEL_DR = 3'd3,
        SEL_AC = 3'd4, SEL_IR = 3'd5, SEL_TR = 3'd6, SEL_MEM = 3'd7
    } bus_sel_e;

    typedef enum logic [3:0] {
        ALU_HOLD, ALU_AND, ALU_ADD, ALU_LOAD, ALU_INCHR,
        ALU_CLR, ALU_CPL, ALU_SHR, ALU_SHL, ALU_INC
    } alu_op_e;

    typedef struct packed {
        logic              link;
        logic [DATA_W-1:0] acc;
    } acc_pair_t;

    function automatic logic [DATA_W-1:0] widen_addr(input logic [ADDR_W-1:0] a);
        return {{(DATA_W-ADDR_W){1'b0}}, a};
    endfunction
endpackage

// File: rtl/acc_cpu_dec.sv
module acc_cpu_dec #(
    parameter int IN_W  = 3,
    parameter int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  code,
    output logic [OUT_N-1:0] hot
);
    for (genvar k = 0; k < OUT_N; k++) begin : g_line
        assign hot[k] = (code == IN_W'(k));
    end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq #(
    parameter int SC_W    = 4,
    parameter int LAST_TS = 6,
    parameter int N_TS    = 1 << SC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic            clr,
    output logic [N_TS-1:0] t
);
    logic [SC_W-1:0] sc_q;

    always_ff @(posedge clk) begin
        if (rst)
            sc_q <= '0;
        else if (run)
            sc_q <= clr ? '0 : sc_q + 1'b1;
    end

    acc_cpu_dec #(.IN_W(SC_W), .OUT_N(N_TS)) u_tdec (.code(sc_q), .hot(t));

    // R2: no instruction runs past its last execute state
    assert_sc_bound_R2: assert property (@(posedge clk) disable iff (rst)
        sc_q <= SC_W'(LAST_TS));
endmodule

// File: rtl/acc_cpu_bus.sv
module acc_cpu_bus
    import acc_cpu_pkg::*;
(
    input  bus_sel_e          sel,
    input  logic [ADDR_W-1:0] ar,
    input  logic [ADDR_W-1:0] pc,
    input  logic [DATA_W-1:0] dr,
    input  logic [DATA_W-1:0] ac,
    input  logic [DATA_W-1:0] ir,
    input  logic [DATA_W-1:0] tr,
    input  logic [DATA_W-1:0] mem,
    output logic [DATA_W-1:0] bus
);
    always_comb begin
        case (sel)
            SEL_AR:  bus = widen_addr(ar);
            SEL_PC:  bus = widen_addr(pc);
            SEL_DR:  bus = dr;
            SEL_AC:  bus = ac;
            SEL_IR:  bus = ir;
            SEL_TR:  bus = tr;
            SEL_MEM: bus = mem;
            default: bus = '0;
        endcase
    end
endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] ac,
    input  logic              link,
    input  logic [DATA_W-1:0] dr,
    input  logic [CHAR_W-1:0] chr,
    output acc_pair_t         res
);
    logic [DATA_W:0] sum;
    assign sum = {1'b0, ac} + {1'b0, dr};

    always_comb begin
        res = '{link: link, acc: ac};
        case (op)
            ALU_AND:   res.acc = ac & dr;
            ALU_ADD:   res = acc_pair_t'(sum);
            ALU_LOAD:  res.acc = dr;
            ALU_INCHR: res.acc = {ac[DATA_W-1:CHAR_W], chr};
            ALU_CLR:   res.acc = '0;
            ALU_CPL:   res.acc = ~ac;
            ALU_SHR:   res = '{link: ac[0], acc: {link, ac[DATA_W-1:1]}};
            ALU_SHL:   res = '{link: ac[DATA_W-1], acc: {ac[DATA_W-2:0], link}};
            ALU_INC:   res.acc = ac + 1'b1;
            default:   res = '{link: link, acc: ac};
        endcase
    end
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [CHAR_W-1:0] in_char,
    input  logic              in_strobe,
    input  logic              out_ack,
    output logic [CHAR_W-1:0] out_char,
    output logic              in_flag,
    output logic              out_flag,
    output logic [ADDR_W-1:0] dbg_pc,
    output logic [DATA_W-1:0] dbg_ac,
    output logic              dbg_halted
);
    logic [ADDR_W-1:0] ar_q, pc_q;
    logic [DATA_W-1:0] dr_q, ac_q, ir_q, tr_q, bus;
    logic [CHAR_W-1:0] inpr_q, outr_q;
    logic ind_q, link_q, s_q, r_q, ien_q, fgi_q, fgo_q;

    logic [N_TS-1:0]  t;
    logic [N_OPC-1:0] d;
    logic sc_clr;

    acc_cpu_seq #(.SC_W(SC_W), .LAST_TS(LAST_TS), .N_TS(N_TS)) u_seq (
        .clk(clk), .rst(rst), .run(s_q), .clr(sc_clr), .t(t));
    acc_cpu_dec #(.IN_W(OPC_W), .OUT_N(N_OPC)) u_odec (
        .code(ir_q[DATA_W-2 -: OPC_W]), .hot(d));

    // state strobes
    logic fet0, fet1, fet2, irq0, irq1, irq2, indir, rop, iop;
    logic rd_op, sta4, bun4, bsa4, bsa5, isz5, isz6, skip;
    assign fet0  = !r_q && t[0];
    assign fet1  = !r_q && t[1];
    assign fet2  = !r_q && t[2];
    assign irq0  = r_q && t[0];
    assign irq1  = r_q && t[1];
    assign irq2  = r_q && t[2];
    assign indir = !d[OP_EXT] && ind_q && t[3];
    assign rop   = d[OP_EXT] && !ind_q && t[3];
    assign iop   = d[OP_EXT] && ind_q && t[3];
    assign rd_op = (d[OP_AND] || d[OP_ADD] || d[OP_LDA] || d[OP_ISZ]) && t[4];
    assign sta4  = d[OP_STA] && t[4];
    assign bun4  = d[OP_BUN] && t[4];
    assign bsa4  = d[OP_BSA] && t[4];
    assign bsa5  = d[OP_BSA] && t[5];
    assign isz5  = d[OP_ISZ] && t[5];
    assign isz6  = d[OP_ISZ] && t[6];

    assign skip = (rop && ((ir_q[RB_SPOS] && !ac_q[DATA_W-1]) ||
                           (ir_q[RB_SNEG] &&  ac_q[DATA_W-1]) ||
                           (ir_q[RB_SZAC] && (ac_q == '0))   ||
                           (ir_q[RB_SZL]  && !link_q)))       ||
                  (iop && ((ir_q[IB_SKIN] && fgi_q) || (ir_q[IB_SKOUT] && fgo_q))) ||
                  (isz6 && (dr_q == '0));

    assign sc_clr = rop || iop || irq2 || bun4 || sta4 || bsa5 || isz6 ||
                    ((d[OP_AND] || d[OP_ADD] || d[OP_LDA]) && t[5]);

    // bus source selection
    bus_sel_e sel;
    always_comb begin
        sel = SEL_NONE;
        if (s_q) begin
            if (bun4 || bsa5)                sel = SEL_AR;
            else if (fet0 || irq0 || bsa4)   sel = SEL_PC;
            else if (isz6)                   sel = SEL_DR;
            else if (sta4 || (iop && ir_q[IB_OUT])) sel = SEL_AC;
            else if (fet2)                   sel = SEL_IR;
            else if (irq1)                   sel = SEL_TR;
            else if (fet1 || indir || rd_op) sel = SEL_MEM;
        end
    end

    acc_cpu_bus u_bus (.sel(sel), .ar(ar_q), .pc(pc_q), .dr(dr_q), .ac(ac_q),
                       .ir(ir_q), .tr(tr_q), .mem(mem_rdata), .bus(bus));

    // accumulator logic
    alu_op_e   alu_op;
    acc_pair_t alu_res;
    logic      link_n;
    always_comb begin
        alu_op = ALU_HOLD;
        if (d[OP_AND] && t[5])        alu_op = ALU_AND;
        else if (d[OP_ADD] && t[5])   alu_op = ALU_ADD;
        else if (d[OP_LDA] && t[5])   alu_op = ALU_LOAD;
        else if (iop && ir_q[IB_IN])  alu_op = ALU_INCHR;
        else if (rop) begin
            if (ir_q[RB_CLA])         alu_op = ALU_CLR;
            else if (ir_q[RB_CMA])    alu_op = ALU_CPL;
            else if (ir_q[RB_SHR])    alu_op = ALU_SHR;
            else if (ir_q[RB_SHL])    alu_op = ALU_SHL;
            else if (ir_q[RB_INC])    alu_op = ALU_INC;
        end
    end

    acc_cpu_alu u_alu (.op(alu_op), .ac(ac_q), .link(link_q), .dr(dr_q),
                       .chr(inpr_q), .res(alu_res));

    always_comb begin
        link_n = alu_res.link;
        if (rop && alu_op != ALU_SHR && alu_op != ALU_SHL) begin
            if (ir_q[RB_CLE])      link_n = 1'b0;
            else if (ir_q[RB_CME]) link_n = ~link_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ar_q <= '0; pc_q <= '0; dr_q <= '0; ac_q <= '0; ir_q <= '0; tr_q <= '0;
            inpr_q <= '0; outr_q <= '0;
            ind_q <= 1'b0; link_q <= 1'b0; s_q <= 1'b1; r_q <= 1'b0;
            ien_q <= 1'b0; fgi_q <= 1'b0; fgo_q <= 1'b0;
        end else begin
            if (in_strobe) inpr_q <= in_char;
            if (in_strobe)                       fgi_q <= 1'b1;
            else if (s_q && iop && ir_q[IB_IN])  fgi_q <= 1'b0;
            if (out_ack)                         fgo_q <= 1'b1;
            else if (s_q && iop && ir_q[IB_OUT]) fgo_q <= 1'b0;

            if (s_q) begin
                if (irq0)                         ar_q <= '0;
                else if (fet0 || fet2 || indir)   ar_q <= bus[ADDR_W-1:0];
                else if (bsa4)                    ar_q <= ar_q + 1'b1;

                if (irq1)                         pc_q <= '0;
                else if (bun4 || bsa5)            pc_q <= bus[ADDR_W-1:0];
                else if (fet1 || irq2 || skip)    pc_q <= pc_q + 1'b1;

                if (rd_op)      dr_q <= bus;
                else if (isz5)  dr_q <= dr_q + 1'b1;
                if (fet1)       ir_q <= bus;
                if (irq0)       tr_q <= bus;
                if (fet2)       ind_q <= ir_q[DATA_W-1];
                if (iop && ir_q[IB_OUT]) outr_q <= bus[CHAR_W-1:0];

                ac_q   <= alu_res.acc;
                link_q <= link_n;

                if (rop && ir_q[RB_HALT]) s_q <= 1'b0;

                if (irq2)                         ien_q <= 1'b0;
                else if (iop && ir_q[IB_EN])      ien_q <= 1'b1;
                else if (iop && ir_q[IB_DIS])     ien_q <= 1'b0;

                if (irq2)                         r_q <= 1'b0;
                else if (!(t[0] || t[1] || t[2]) && ien_q && (fgi_q || fgo_q))
                                                  r_q <= 1'b1;
            end
        end
    end

    assign mem_addr   = ar_q;
    assign mem_rd     = (sel == SEL_MEM);
    assign mem_wr     = s_q && (sta4 || bsa4 || isz6 || irq1);
    assign mem_wdata  = bus;
    assign out_char   = outr_q;
    assign in_flag    = fgi_q;
    assign out_flag   = fgo_q;
    assign dbg_pc     = pc_q;
    assign dbg_ac     = ac_q;
    assign dbg_halted = !s_q;

    // R1: every fetch reads the word the program counter points at
    assert_fetch_at_pc_R1: assert property (@(posedge clk) disable iff (rst)
        (s_q && !r_q && t[1]) |-> (mem_rd && mem_addr == pc_q));
    // R3: strobes exclusive
    assert_rw_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
    // R3: writes only in execute states or the call's store state
    assert_wr_window_R3: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (t[4] || t[5] || t[6] || (r_q && t[1])));
    // R2: register and I/O operations end after state 3
    assert_short_op_len_R2: assert property (@(posedge clk) disable iff (rst)
        (s_q && !r_q && t[3] && d[OP_EXT]) |=> t[0]);
    // R12: call lands at word 1 with calls disabled
    assert_call_vector_R12: assert property (@(posedge clk) disable iff (rst)
        (s_q && r_q && t[2]) |=> (pc_q == ADDR_W'(1) && !ien_q && !r_q));
    // R10: nothing moves while halted
    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
        !s_q |=> (!s_q && $stable(pc_q) && $stable(ac_q) && !mem_rd && !mem_wr));
endmodule

// File: tb/acc_cpu_bench.sv
`timescale 1ns/1ps
module acc_cpu_bench;
    logic        clk, rst;
    logic [11:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [7:0]  in_char, out_char;
    logic        in_strobe, out_ack, in_flag, out_flag, dbg_halted;
    logic [11:0] dbg_pc;
    logic [15:0] dbg_ac;

    acc_cpu u_acc_cpu (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .in_char(in_char),
        .in_strobe(in_strobe), .out_ack(out_ack), .out_char(out_char),
        .in_flag(in_flag), .out_flag(out_flag), .dbg_pc(dbg_pc), .dbg_ac(dbg_ac),
        .dbg_halted(dbg_halted));

    initial clk = 1'b0;
    always #2 clk = ~clk;

    int total = 0, bad = 0;
    int cyc = 0, wd = 0;

    logic [15:0] mem [0:255];
    assign mem_rdata = mem[mem_addr[7:0]];
    always @(posedge clk) if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;

    always @(posedge clk) begin
        if (rst) cyc <= 0; else cyc <= cyc + 1;
    end

    typedef struct { int a; int d; string req; } wr_item_t;
    wr_item_t exp_q[$];

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic expect_wr(input int a, input int d, input string req);
        wr_item_t it;
        it.a = a; it.d = d; it.req = req;
        exp_q.push_back(it);
    endtask

    // monitor: compares each memory write with the scoreboard
    always @(negedge clk) begin
        if (!rst && mem_wr) begin
            if (exp_q.size() == 0) begin
                chk("R3", "unexpected write addr", int'(mem_addr), -1);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(it.req, "write addr", int'(mem_addr), it.a);
                chk(it.req, "write data", int'(mem_wdata), it.d);
            end
        end
    end

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    task automatic clear_mem();
        for (int k = 0; k < 256; k++) mem[k] = 16'h0000;
    endtask

    task automatic put(input int a, input int v);
        mem[a] = 16'(v);
    endtask

    task automatic wait_halt(input string req, output int when);
        when = -1;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk);
            if (dbg_halted) begin when = cyc; break; end
        end
        if (when < 0) chk(req, "halt reached", 0, 1);
    endtask

    task automatic restart();
        rst = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    int n, pc_hold, ac_hold;

    initial begin
        rst = 1'b1; in_strobe = 1'b0; out_ack = 1'b0; in_char = 8'h00;
        clear_mem();
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "pc after reset", dbg_pc, 0);
        chk("R1", "ac after reset", dbg_ac, 0);
        chk("R1", "halted after reset", dbg_halted, 0);
        chk("R13", "in_flag after reset", in_flag, 0);
        chk("R13", "out_flag after reset", out_flag, 0);

        // ---- program 1: memory-reference group, indirect, skips ----
        clear_mem();
        put(12'h000, 16'h4010);             // BUN 0x10
        put(12'h010, 16'h2040);             // LDA 40
        put(12'h011, 16'h1041);             // ADD 41
        put(12'h012, 16'h3042);             // STA 42
        put(12'h013, 16'h0043);             // AND 43
        put(12'h014, 16'h9044);             // ADD I 44
        put(12'h015, 16'hB044);             // STA I 44
        put(12'h016, 16'h5030);             // BSA 30
        put(12'h017, 16'h7001);             // HLT (return target)
        put(12'h031, 16'h6046);             // ISZ 46 -> skips
        put(12'h032, 16'h7001);             // HLT skipped
        put(12'h033, 16'h6047);             // ISZ 47 no skip
        put(12'h034, 16'hC030);             // BUN I 30
        put(12'h040, 16'h00F0);
        put(12'h041, 16'hFF20);
        put(12'h043, 16'h0013);
        put(12'h044, 16'h0045);
        put(12'h045, 16'h0005);
        put(12'h046, 16'hFFFF);
        put(12'h047, 16'h0007);
        expect_wr(12'h042, 16'h0010, "R4");  // add carry result stored (R5)
        expect_wr(12'h045, 16'h0015, "R7");  // indirect store
        expect_wr(12'h030, 16'h0017, "R5");  // return address
        expect_wr(12'h046, 16'h0000, "R6");
        expect_wr(12'h047, 16'h0008, "R6");
        @(negedge clk); rst = 1'b0;
        wait_halt("R10", n);
        // BUN5 LDA6 ADD6 STA5 AND6 ADDI6 STAI5 BSA6 ISZ7 ISZ7 BUNI5 HLT4
        chk("R2", "clocks program 1", n, 68);
        chk("R5", "pc after return path", dbg_pc, 12'h018);
        chk("R4", "ac after indirect add", dbg_ac, 16'h0015);
        pc_hold = dbg_pc; ac_hold = dbg_ac;
        repeat (12) @(negedge clk);
        chk("R10", "pc frozen", dbg_pc, pc_hold);
        chk("R10", "ac frozen", dbg_ac, ac_hold);
        chk("R10", "still halted", dbg_halted, 1);
        chk("R3", "pending writes program 1", exp_q.size(), 0);
        chk("R6", "memory after isz", mem[8'h46], 0);
        restart();

        // ---- program 2: register operations and tests ----
        clear_mem();
        put(12'h000, 16'h7800);  // CLA
        put(12'h001, 16'h7200);  // CMA -> FFFF
        put(12'h002, 16'h7020);  // INC -> 0000
        put(12'h003, 16'h7004);  // SZA skip
        put(12'h004, 16'h7001);
        put(12'h005, 16'h7100);  // CME -> link 1
        put(12'h006, 16'h7080);  // CIR -> 8000, link 0
        put(12'h007, 16'h7008);  // SNA skip
        put(12'h008, 16'h7001);
        put(12'h009, 16'h7040);  // CIL -> 0000, link 1
        put(12'h00A, 16'h7002);  // SZE no skip
        put(12'h00B, 16'h7400);  // CLE
        put(12'h00C, 16'h7002);  // SZE skip
        put(12'h00D, 16'h7001);
        put(12'h00E, 16'h7010);  // SPA skip
        put(12'h00F, 16'h7001);
        put(12'h010, 16'h7020);  // INC -> 1
        put(12'h011, 16'h3020);  // STA 20
        put(12'h012, 16'h7080);  // CIR -> 0, link 1
        put(12'h013, 16'h7040);  // CIL -> 1, link 0
        put(12'h014, 16'h3021);  // STA 21
        put(12'h015, 16'h7001);  // HLT
        expect_wr(12'h020, 16'h0001, "R8");
        expect_wr(12'h021, 16'h0001, "R8");
        @(negedge clk); rst = 1'b0;
        wait_halt("R9", n);
        chk("R2", "clocks program 2", n, 74);
        chk("R9", "pc after skip chain", dbg_pc, 12'h016);
        chk("R8", "ac after rotations", dbg_ac, 16'h0001);
        chk("R3", "pending writes program 2", exp_q.size(), 0);
        restart();

        // ---- program 3: I/O, flags and the hardware call ----
        clear_mem();
        put(12'h000, 16'h400F);  // BUN 0F
        put(12'h001, 16'h4050);  // BUN 50 (call vector)
        put(12'h00F, 16'h2040);  // LDA 40 -> AB00
        put(12'h010, 16'hF200);  // SKI
        put(12'h011, 16'h4010);  // BUN 10
        put(12'h012, 16'hF800);  // INP
        put(12'h013, 16'h3041);  // STA 41
        put(12'h014, 16'hF400);  // OUT
        put(12'h015, 16'hF100);  // SKO no skip
        put(12'h016, 16'h4018);  // BUN 18
        put(12'h017, 16'h7001);
        put(12'h018, 16'hF080);  // ION
        put(12'h019, 16'h7800);  // CLA
        put(12'h01A, 16'h401A);  // BUN 1A (wait loop)
        put(12'h040, 16'hAB00);
        put(12'h050, 16'hF100);  // SKO skip
        put(12'h051, 16'h7001);
        put(12'h052, 16'h2000);  // LDA 0
        put(12'h053, 16'h3042);  // STA 42
        put(12'h054, 16'h7001);  // HLT
        expect_wr(12'h041, 16'hAB5A, "R11");
        expect_wr(12'h000, 16'h001A, "R12");
        expect_wr(12'h042, 16'h001A, "R12");
        @(negedge clk); rst = 1'b0;
        repeat (30) @(negedge clk);
        chk("R11", "in_flag before strobe", in_flag, 0);
        in_char = 8'h5A; in_strobe = 1'b1;
        @(negedge clk); in_strobe = 1'b0; in_char = 8'h00;
        chk("R13", "in_flag after strobe", in_flag, 1);
        n = 0;
        for (int k = 0; k < 500; k++) begin
            @(negedge clk);
            if (out_char == 8'h5A) begin n = 1; break; end
        end
        chk("R11", "output character", out_char, 8'h5A);
        chk("R11", "input flag cleared by input op", in_flag, 0);
        repeat (40) @(negedge clk);
        chk("R12", "no call before flag", dbg_pc >= 12'h018 && dbg_pc <= 12'h01B, 1);
        out_ack = 1'b1;
        @(negedge clk); out_ack = 1'b0;
        chk("R13", "out_flag after ack", out_flag, 1);
        wait_halt("R12", n);
        chk("R12", "pc after service", dbg_pc, 12'h055);
        chk("R12", "ac holds saved pc", dbg_ac, 16'h001A);
        chk("R11", "out_flag kept by test", out_flag, 1);
        chk("R3", "pending writes program 3", exp_q.size(), 0);

        finish_run();
    end
endmodule